// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block decides whether a received frame's 48-bit destination address falls into a set of addresses that software has marked as wanted. For each address it runs a CRC-32 over the six address bytes and takes the top bits of the remainder as an index. That index picks one bit out of a table held in sixteen 32-bit registers. The frame hits when the chosen bit is 1. A hit can still be a false positive, because many addresses share each table entry.

A mode input decides how the sixteen registers are used. With the mode clear, they form two 256-entry tables, each indexed by 8 CRC bits. Registers 0 to 7 serve individual (unicast) addresses. Registers 8 to 15 serve group (multicast) addresses. With the mode set, all sixteen registers form one 512-entry table, indexed by 9 CRC bits. That table serves group addresses only.

The receive path presents the address with a one-cycle strobe. One cycle later the block returns the hit flag, the group/individual flag and the index. These results stay unchanged until the next strobe. Software may write any table register at any moment.

Top module: `da_hash_filter`

## Requirements
- R1: The CRC remainder starts at 0xFFFFFFFF. It takes the address bytes in wire order: addr_i[47:40] first and addr_i[7:0] last. Each byte is fed least significant bit first through polynomial 0x04C11DB7 (shift left, feedback = bit 31 xor the data bit). No final inversion is applied. index_o is remainder bits 31:24 zero-extended when ext_mode_i is 0, and remainder bits 31:23 when ext_mode_i is 1.
- R2: With ext_mode_i = 0, an individual address looks up register index[7:5]. A group address looks up register 8 + index[7:5]. In both cases the bit looked up is 31 - index[4:0].
- R3: With ext_mode_i = 1, a group address looks up register index[8:5], bit 31 - index[4:0].
- R4: With ext_mode_i = 1, an individual address never hits, whatever the table holds.
- R5: mcast_o reports addr_i[40] of the looked-up address: 1 for a group address, 0 for an individual address.
- R6: After reset every table register is zero and hit_o, mcast_o and index_o are zero. No address hits until software sets a table bit.
- R7: hit_o, mcast_o and index_o change only one cycle after a cycle with addr_vld_i high. Between strobes they hold their values, even while addr_i, ext_mode_i or the table change.
- R8: reg_we_i writes reg_wdata_i into register reg_sel_i at any time. A lookup in the same cycle as a write uses the old contents. The following lookup uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_vld_i | input | 1 | Destination address strobe |
| addr_i | input | 48 | Destination address, first wire byte in bits 47:40 |
| ext_mode_i | input | 1 | 1 = single 512-entry group table |
| reg_we_i | input | 1 | Table register write enable |
| reg_sel_i | input | 4 | Table register number (0-7 individual, 8-15 group) |
| reg_wdata_i | input | 32 | Table register write data |
| hit_o | output | 1 | Selected table bit was set |
| mcast_o | output | 1 | Looked-up address was a group address |
| index_o | output | 9 | Computed table index |

## Verification
A table write and an address lookup can land in the same clock cycle. The bench provokes this by raising reg_we_i and addr_vld_i on the same edge. The write sets exactly the bit that the address selects, starting from an all-zero table. The lookup on that edge must report no hit, because it sees the old contents. A second lookup of the same address, one cycle later, must report a hit.

// File: rtl/dahf_pkg.sv
package dahf_pkg;
  localparam int unsigned ADDR_W   = 48;
  localparam int unsigned CRC_W    = 32;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned NUM_REG  = 16;
  localparam int unsigned SEL_W    = $clog2(NUM_REG);
  localparam int unsigned BIT_W    = $clog2(REG_W);
  localparam int unsigned IDX_W    = SEL_W + BIT_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef logic [NUM_REG-1:0][REG_W-1:0] tbl_t;

  typedef struct packed {
    logic             hit;
    logic             mcast;
    logic [IDX_W-1:0] index;
  } lkp_res_t;
endpackage

// File: rtl/dahf_crc.sv
module dahf_crc
  import dahf_pkg::*;
#(
  parameter int unsigned DATA_W = ADDR_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [CRC_W-1:0] stage [DATA_W+1];
  assign stage[0] = CRC_INIT;

  // byte k sits at data_i[DATA_W-1-8k -: 8], fed lsb first
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam int unsigned BYTE_N = g / 8;
    localparam int unsigned BIT_N  = g % 8;
    localparam int unsigned POS    = DATA_W - 8 * (BYTE_N + 1) + BIT_N;
    logic fb;
    assign fb           = stage[g][CRC_W-1] ^ data_i[POS];
    assign stage[g+1]   = {stage[g][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  end

  assign crc_o = stage[DATA_W];

  logic unused_ok;
  assign unused_ok = ^NBYTES;
endmodule

// File: rtl/dahf_table.sv
module dahf_table
  import dahf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output tbl_t             tbl_o
);
  tbl_t tbl_q;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tbl_q[r] <= '0;
      else if (we_i && (sel_i == SEL_W'(r)))      tbl_q[r] <= wdata_i;
    end
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/dahf_select.sv
module dahf_select
  import dahf_pkg::*;
(
  input  tbl_t             tbl_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             ext_i,
  input  logic             mcast_i,
  output lkp_res_t         res_o
);
  logic [SEL_W-1:0] sel;
  logic [BIT_W-1:0] bpos;
  logic [REG_W-1:0] word;

  always_comb begin
    if (ext_i) begin
      sel  = crc_i[CRC_W-1 -: SEL_W];
      bpos = crc_i[CRC_W-1-SEL_W -: BIT_W];
    end else begin
      // half table chosen by address type
      sel  = {mcast_i, crc_i[CRC_W-1 -: SEL_W-1]};
      bpos = crc_i[CRC_W-SEL_W -: BIT_W];
    end
    word = tbl_i[sel];
  end

  always_comb begin
    res_o.mcast = mcast_i;
    // entry 0 is register bit 31
    res_o.hit   = word[REG_W-1-int'(bpos)] && (mcast_i || !ext_i);
    res_o.index = ext_i ? crc_i[CRC_W-1 -: IDX_W]
                        : {1'b0, crc_i[CRC_W-1 -: IDX_W-1]};
  end
endmodule

// File: rtl/da_hash_filter.sv
module da_hash_filter
  import dahf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ext_mode_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              hit_o,
  output logic              mcast_o,
  output logic [IDX_W-1:0]  index_o
);
  tbl_t             tbl_w;
  logic [CRC_W-1:0] crc_w;
  lkp_res_t         res_d, res_q;

  dahf_crc #(.DATA_W(ADDR_W)) u_crc (
    .data_i (addr_i),
    .crc_o  (crc_w)
  );

  dahf_table u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .tbl_o   (tbl_w)
  );

  dahf_select u_select (
    .tbl_i   (tbl_w),
    .crc_i   (crc_w),
    .ext_i   (ext_mode_i),
    .mcast_i (addr_i[ADDR_W-8]),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         res_q <= '0;
    else if (addr_vld_i) res_q <= res_d;
  end

  assign hit_o   = res_q.hit;
  assign mcast_o = res_q.mcast;
  assign index_o = res_q.index;
endmodule

// File: rtl/dahf_checker.sv
module dahf_checker
  import dahf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ext_mode_i,
  input logic              hit_o,
  input logic              mcast_o,
  input logic [IDX_W-1:0]  index_o,
  input tbl_t              tbl_i
);
  assert_norm_index_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i && !ext_mode_i |=> index_o[IDX_W-1] == 1'b0);

  assert_ext_ucast_nohit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i && ext_mode_i && !addr_i[ADDR_W-8] |=> !hit_o);

  assert_mcast_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i |=> mcast_o == $past(addr_i[ADDR_W-8]));

  assert_empty_nohit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_i && (tbl_i == '0) |=> !hit_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> $stable({hit_o, mcast_o, index_o}));
endmodule

bind da_hash_filter dahf_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_vld_i (addr_vld_i),
  .addr_i     (addr_i),
  .ext_mode_i (ext_mode_i),
  .hit_o      (hit_o),
  .mcast_o    (mcast_o),
  .index_o    (index_o),
  .tbl_i      (tbl_w)
);

// File: tb/da_hash_filter_tb_top.sv
module da_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_vld = 1'b0;
  logic [47:0] addr = '0;
  logic        ext = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic        hit, mcast;
  logic [8:0]  index;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  da_hash_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_vld_i(addr_vld), .addr_i(addr),
    .ext_mode_i(ext), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .hit_o(hit), .mcast_o(mcast), .index_o(index)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // {addr, ext, prog (0 none, 1 own entry, 2 same bit other half), exp_hit}
  localparam logic [51:0] VEC [12] = '{
    {48'h0011_2233_4455, 1'b0, 2'd1, 1'b1},
    {48'h0011_2233_4455, 1'b0, 2'd2, 1'b0},
    {48'h0100_5E00_0001, 1'b0, 2'd1, 1'b1},
    {48'h0100_5E00_0001, 1'b0, 2'd2, 1'b0},
    {48'hFFFF_FFFF_FFFF, 1'b0, 2'd0, 1'b0},
    {48'h3333_0000_0001, 1'b1, 2'd1, 1'b1},
    {48'h0180_C200_0000, 1'b1, 2'd1, 1'b1},
    {48'h00A0_C912_3456, 1'b1, 2'd1, 1'b0},
    {48'hDEAD_BEEF_0000, 1'b0, 2'd1, 1'b1},
    {48'hFFFF_FFFF_FFFF, 1'b1, 2'd2, 1'b0},
    {48'h0200_0000_0001, 1'b0, 2'd1, 1'b1},
    {48'h3333_0000_0001, 1'b0, 2'd1, 1'b1}
  };

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ b[j];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [8:0] ref_idx(input logic [47:0] a, input logic e);
    logic [31:0] c;
    c = ref_crc(a);
    return e ? c[31:23] : {1'b0, c[31:24]};
  endfunction

  function automatic logic [3:0] ref_sel(input logic [47:0] a, input logic e);
    logic [8:0] i;
    i = ref_idx(a, e);
    return e ? i[8:5] : {a[40], i[7:5]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < 16; r++) wr(4'(r), 32'h0);
  endtask

  task automatic lookup(input logic [47:0] a, input logic e);
    @(negedge clk);
    addr_vld = 1'b1; addr = a; ext = e;
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  task automatic set_entry(input logic [47:0] a, input logic e, input logic other);
    logic [8:0] i;
    logic [3:0] s;
    i = ref_idx(a, e);
    s = ref_sel(a, e);
    if (other) s = s ^ 4'h8;
    wr(s, 32'h8000_0000 >> i[4:0]);
  endtask

  initial begin
    logic [47:0] a;
    logic [8:0]  i;
    logic        h0, m0;
    logic [8:0]  x0;
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 hit after reset", 32'(hit), 32'h0);
    check("R6 mcast after reset", 32'(mcast), 32'h0);
    check("R6 index after reset", 32'(index), 32'h0);
    rst_n = 1'b1;
    lookup(48'h0100_5E00_0001, 1'b0);
    check("R6 empty table mcast lookup", 32'(hit), 32'h0);
    lookup(48'h0011_2233_4455, 1'b0);
    check("R6 empty table ucast lookup", 32'(hit), 32'h0);

    // vector walk: R1 R2 R3 R4 R5
    foreach (VEC[v]) begin
      a = VEC[v][51:4];
      clear_all();
      if (VEC[v][2:1] != 2'd0) set_entry(a, VEC[v][3], VEC[v][2:1] == 2'd2);
      lookup(a, VEC[v][3]);
      check($sformatf("R2/R3/R4 hit vec %0d", v), 32'(hit), 32'(VEC[v][0]));
      check($sformatf("R5 mcast vec %0d", v), 32'(mcast), 32'(a[40]));
      check($sformatf("R1 index vec %0d", v), 32'(index), 32'(ref_idx(a, VEC[v][3])));
    end

    // R3: extended group entries in both register halves
    for (int want = 0; want < 2; want++) begin
      a = 48'h0100_5E00_0000;
      for (int n = 0; n < 256; n++) begin
        a[7:0] = 8'(n);
        i = ref_idx(a, 1'b1);
        if (i[8] == 1'(want)) break;
      end
      clear_all();
      set_entry(a, 1'b1, 1'b0);
      lookup(a, 1'b1);
      check($sformatf("R3 ext hit index[8]=%0d", want), 32'(hit), 32'h1);
      check($sformatf("R3 ext index[8]=%0d", want), 32'(index), 32'(i));
      lookup(a, 1'b0);
      check($sformatf("R2 same bits normal mode index[8]=%0d", want), 32'(hit), 32'h0);
    end

    // R8: write and lookup in the same cycle
    a = 48'h0100_5E7F_0001;
    i = ref_idx(a, 1'b0);
    clear_all();
    @(negedge clk);
    addr_vld = 1'b1; addr = a; ext = 1'b0;
    we = 1'b1; sel = ref_sel(a, 1'b0); wdata = 32'h8000_0000 >> i[4:0];
    @(negedge clk);
    addr_vld = 1'b0; we = 1'b0;
    check("R8 same-cycle lookup sees old table", 32'(hit), 32'h0);
    lookup(a, 1'b0);
    check("R8 next lookup sees new table", 32'(hit), 32'h1);

    // R7: outputs hold while inputs and table change
    h0 = hit; m0 = mcast; x0 = index;
    @(negedge clk);
    addr = 48'h0011_2233_4455; ext = 1'b1;
    repeat (3) @(negedge clk);
    clear_all();
    check("R7 hit held", 32'(hit), 32'(h0));
    check("R7 mcast held", 32'(mcast), 32'(m0));
    check("R7 index held", 32'(index), 32'(x0));
    lookup(a, 1'b0);
    check("R7/R8 cleared table after idle write", 32'(hit), 32'h0);

    // R8: a full-word write replaces all bits
    wr(4'hF, 32'hFFFF_FFFF);
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'hF, 32'h0);
    lookup(48'hFFFF_FFFF_FFFF, 1'b1);
    i = ref_idx(48'hFFFF_FFFF_FFFF, 1'b1);
    check("R8 overwrite reg 15", 32'(hit), 32'(i[8:5] == 4'h7));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule